// File: doc/BRIEF.md
# BPSK Coherent Demodulator

This block turns a stream of binary phase-shift keyed samples back into data bits. Each incoming 16-bit signed sample is multiplied by a locally generated carrier. The product then passes through a 128-tap low-pass filter, and the sign of the filtered value gives the recovered bit. The filter has only one multiplier and one accumulator. It takes one coefficient per clock, so one frame of 128 clocks yields one filtered value and consumes one new sample. The input is therefore decimated by 128 on entry, and the filter result is held for a whole frame.

The local carrier runs at a quarter of the frame rate. Its values are +A, 0, -A, 0 with A = 32767, and it advances one step per frame. The sample entering the filter in any frame is the mixer output in that frame's last cycle. That output comes from the input presented three cycles earlier, in frame cycle 124. The tap walk is sequenced by a three-state machine. ST_FIRST_TAP starts a fresh sum and always moves on to ST_MID_TAP. ST_MID_TAP stays put until the counter shows cycle 126 and then moves to ST_LAST_TAP. ST_LAST_TAP closes the sum, stores the newest sample into the delay line and always returns to ST_FIRST_TAP. The phase and symbol timing are assumed to be aligned already.

Top module: `bpsk_coherent_demod`

## Requirements
- R1: While rst_n is low, filt_out is 0 and filt_valid, out_bit and out_valid are 0. After release the delay line holds zeros.
- R2: The carrier value in frame f, counted from reset release, is +32767, 0, -32767 or 0 for f mod 4 = 0, 1, 2 or 3. The mixed sample is floor(x*c / 32768).
- R3: Only the input presented in frame cycle 124 (cycle 128f+124 after reset release) reaches the filter, through a 3-cycle mixer. Input in every other cycle has no effect on any output.
- R4: Tap k (k = 0 newest) has weight 256*(k+1) for k < 64 and 256*(128-k) for k >= 64.
- R5: At the end of frame f, filt_out becomes the sum over k of weight(k) * m(f-1-k), where m(j) is the mixed sample stored at the end of frame j. Samples from before reset release count as 0.
- R6: filt_valid is a one-cycle pulse in cycle 128(f+1) after reset release, and filt_out holds its value between pulses.
- R7: One cycle after each filt_valid pulse, out_valid pulses and out_bit becomes 1 if the filtered value is >= 0, or 0 if it is negative. out_bit holds between pulses.
- R8: The 39-bit sum is exact for full-scale inputs of both signs, with no wrap.
- R9: A frame is 128 clocks counted from reset release, and exactly one filtered value is produced per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sample | input | 16 | Received sample, two's complement |
| filt_out | output | 39 | Low-pass filter result, signed |
| filt_valid | output | 1 | Pulse when filt_out updates |
| out_bit | output | 1 | Recovered data bit |
| out_valid | output | 1 | Pulse when out_bit updates |

## Verification
The bench fills every non-sampling cycle with random input. A design that picks the wrong capture cycle, or lets other cycles leak into the delay line, then gives filtered values that diverge from the model at once. Full-scale segments of both signs drive the sum toward its largest magnitude, so a narrow accumulator would show up as a sign flip in out_bit. All-zero input gives a result of exactly 0, which must slice to 1; a strict greater-than comparison would return 0 there. Symbol reversals check that the newest sample sits at tap 0 and that the carrier steps once per frame: a reversed delay line or a carrier running too fast would give sums different from the model in every frame.

// File: rtl/bpsk_demod_pkg.sv
`timescale 1ns/1ps
package bpsk_demod_pkg;

    // Tap sequencing states of the shared multiply-accumulate filter
    typedef enum logic [1:0] {
        ST_FIRST_TAP = 2'd0,
        ST_MID_TAP   = 2'd1,
        ST_LAST_TAP  = 2'd2
    } tap_state_t;

endpackage

// File: rtl/local_cosine_gen.sv
`timescale 1ns/1ps
module local_cosine_gen #(
    parameter int W   = 16,
    parameter int AMP = 32767
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_end,
    output logic signed [W-1:0] cos_val
);

    localparam logic signed [W-1:0] POS_PEAK = W'(AMP);
    localparam logic signed [W-1:0] NEG_PEAK = -POS_PEAK;

    logic [1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 2'd0;
        else if (frame_end)
            phase_q <= phase_q + 2'd1;
    end

    always_comb begin
        unique case (phase_q)
            2'd0:    cos_val = POS_PEAK;
            2'd2:    cos_val = NEG_PEAK;
            default: cos_val = '0;
        endcase
    end

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(cos_val));

endmodule

// File: rtl/mixer_pipe.sv
`timescale 1ns/1ps
module mixer_pipe #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] in_x,
    input  logic signed [W-1:0] in_c,
    output logic signed [W-1:0] mix
);

    localparam int PW = 2 * W;

    logic signed [W-1:0]  x_q, c_q;
    logic signed [PW-1:0] p_q;

    // Three register stages: operands, product, scaled result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            c_q <= '0;
            p_q <= '0;
            mix <= '0;
        end else begin
            x_q <= in_x;
            c_q <= in_c;
            p_q <= x_q * c_q;
            mix <= W'(p_q >>> (W - 1));
        end
    end

endmodule

// File: rtl/mac_fir.sv
`timescale 1ns/1ps
module mac_fir
    import bpsk_demod_pkg::*;
#(
    parameter int W    = 16,
    parameter int CW   = 16,
    parameter int TAPS = 128,
    parameter int STEP = 256
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic signed [W-1:0]                          sample_in,
    output logic                                         frame_end,
    output logic signed [W+CW+$clog2(TAPS)-1:0]          result,
    output logic                                         res_valid
);

    localparam int PTR_W  = $clog2(TAPS);
    localparam int PROD_W = W + CW;
    localparam int ACC_W  = PROD_W + PTR_W;
    localparam int HALF   = TAPS / 2;

    // Triangular low-pass weight for tap position idx
    function automatic logic signed [CW-1:0] tap_weight(input int unsigned idx);
        int unsigned rank;
        rank = (idx < HALF) ? idx + 1 : TAPS - idx;
        return CW'(rank * STEP);
    endfunction

    tap_state_t state, state_nx;
    logic [PTR_W-1:0]         cnt_q, wp_q, rd_idx;
    logic signed [W-1:0]      dline [TAPS];
    logic signed [W-1:0]      tap_val;
    logic signed [CW-1:0]     coef;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  ext, acc_q, sum;
    logic                     acc_load, acc_close;

    // Frame counter
    assign frame_end = (cnt_q == PTR_W'(TAPS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= frame_end ? '0 : cnt_q + PTR_W'(1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_FIRST_TAP;
        else
            state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FIRST_TAP: state_nx = ST_MID_TAP;
            ST_MID_TAP:   if (cnt_q == PTR_W'(TAPS - 2)) state_nx = ST_LAST_TAP;
            ST_LAST_TAP:  state_nx = ST_FIRST_TAP;
            default:      state_nx = ST_FIRST_TAP;
        endcase
    end

    // State outputs
    always_comb begin
        acc_load  = 1'b0;
        acc_close = 1'b0;
        unique case (state)
            ST_FIRST_TAP: acc_load  = 1'b1;
            ST_LAST_TAP:  acc_close = 1'b1;
            default:      ;
        endcase
    end

    // Tap fetch: newest stored sample at tap 0
    assign rd_idx  = wp_q - PTR_W'(1) - cnt_q;
    assign tap_val = dline[rd_idx];
    assign coef    = tap_weight(32'(cnt_q));
    assign prod    = tap_val * coef;
    assign ext     = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    assign sum     = acc_q + ext;

    // Circular delay line, written once per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++)
                dline[i] <= '0;
            wp_q <= '0;
        end else if (acc_close) begin
            dline[wp_q] <= sample_in;
            wp_q        <= wp_q + PTR_W'(1);
        end
    end

    // Accumulator and frame result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            result    <= '0;
            res_valid <= 1'b0;
        end else begin
            acc_q     <= acc_load ? ext : sum;
            res_valid <= acc_close;
            if (acc_close)
                result <= sum;
        end
    end

    // R9
    last_tap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end == (state == ST_LAST_TAP));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_load && (acc_q[ACC_W-1] == ext[ACC_W-1])) |-> (sum[ACC_W-1] == acc_q[ACC_W-1]));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(wp_q));

endmodule

// File: rtl/zero_slicer.sv
`timescale 1ns/1ps
module zero_slicer #(
    parameter int VW = 39
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [VW-1:0] value,
    input  logic                 in_valid,
    output logic                 bit_q,
    output logic                 valid_q
);

    logic at_or_above;
    logic pick;

    assign at_or_above = (value >= 0);
    assign pick        = at_or_above ? 1'b1 : 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid)
                bit_q <= pick;
        end
    end

    // R7
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(bit_q));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q == $past(in_valid));

endmodule

// File: rtl/bpsk_coherent_demod.sv
`timescale 1ns/1ps
module bpsk_coherent_demod #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int TAPS     = 128,
    parameter int STEP     = 256,
    parameter int AMP      = 32767
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic signed [SAMPLE_W-1:0]                      in_sample,
    output logic signed [SAMPLE_W+COEF_W+$clog2(TAPS)-1:0]  filt_out,
    output logic                                            filt_valid,
    output logic                                            out_bit,
    output logic                                            out_valid
);

    localparam int ACC_W = SAMPLE_W + COEF_W + $clog2(TAPS);

    logic                       frame_end;
    logic signed [SAMPLE_W-1:0] carrier;
    logic signed [SAMPLE_W-1:0] mixed;

    local_cosine_gen #(.W(SAMPLE_W), .AMP(AMP)) u_cos (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .cos_val   (carrier)
    );

    mixer_pipe #(.W(SAMPLE_W)) u_mix (
        .clk   (clk),
        .rst_n (rst_n),
        .in_x  (in_sample),
        .in_c  (carrier),
        .mix   (mixed)
    );

    mac_fir #(.W(SAMPLE_W), .CW(COEF_W), .TAPS(TAPS), .STEP(STEP)) u_fir (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (mixed),
        .frame_end (frame_end),
        .result    (filt_out),
        .res_valid (filt_valid)
    );

    zero_slicer #(.VW(ACC_W)) u_slice (
        .clk      (clk),
        .rst_n    (rst_n),
        .value    (filt_out),
        .in_valid (filt_valid),
        .bit_q    (out_bit),
        .valid_q  (out_valid)
    );

    // R6
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_valid |-> $stable(filt_out));

endmodule

// File: tb/sim_bpsk_coherent_demod.sv
`timescale 1ns/1ps
module sim_bpsk_coherent_demod;

    localparam int NFRAMES = 1200;
    localparam int FLEN    = 128;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] drv = '0;
    logic signed [38:0] filt_out;
    logic               filt_valid, out_bit, out_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bpsk_coherent_demod u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_sample  (drv),
        .filt_out   (filt_out),
        .filt_valid (filt_valid),
        .out_bit    (out_bit),
        .out_valid  (out_valid)
    );

    // Behavioural reference model state
    int      cyc = 0;
    int      mixq[$] = '{0, 0, 0};
    longint  dl[128];
    int      wp_m = 0;
    longint  filt_m = 0;
    bit      fv_m = 0, bit_m = 0, ov_m = 0;

    initial for (int i = 0; i < 128; i++) dl[i] = 0;

    function automatic longint coefm(int k);
        return longint'((k < 64) ? (k + 1) : (128 - k)) * 256;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            int     ph, cosv, mixcur;
            longint s;
            ph   = (cyc / FLEN) % 4;
            cosv = (ph == 0) ? 32767 : ((ph == 2) ? -32767 : 0);
            mixcur = mixq.pop_front();
            mixq.push_back(int'((longint'(drv) * cosv) >>> 15));
            ov_m = fv_m;
            if (fv_m) bit_m = (filt_m >= 0);
            if ((cyc % FLEN) == FLEN - 1) begin
                s = 0;
                for (int k = 0; k < 128; k++) s += coefm(k) * dl[(wp_m - 1 - k) & 127];
                filt_m = s;
                fv_m = 1'b1;
                dl[wp_m] = longint'(mixcur);
                wp_m = (wp_m + 1) % 128;
            end else begin
                fv_m = 1'b0;
            end
            cyc++;
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(filt_out == 0, "R1 reset filt_out", longint'(filt_out), 0);
                chk(!filt_valid && !out_valid, "R1 reset valids", {filt_valid, out_valid}, 0);
                chk(!out_bit, "R1 reset out_bit", out_bit, 0);
            end else begin
                chk(longint'(filt_out) == filt_m, "R2 R3 R4 R5 R8 filt_out",
                    longint'(filt_out), filt_m);
                chk(filt_valid == fv_m, "R6 R9 filt_valid", filt_valid, fv_m);
                chk(out_valid == ov_m, "R7 out_valid", out_valid, ov_m);
                chk(out_bit == bit_m, "R7 out_bit", out_bit, bit_m);
            end
        end
    end

    function automatic logic signed [15:0] stim(int c);
        int f, sym, amp;
        f = c / FLEN;
        if ((c % FLEN) != FLEN - 4 || (f % 2) == 1) return 16'($urandom);
        if (f < 40) return '0;
        if (f < 340) begin sym = 1; amp = 20000; end
        else if (f < 640) return (f % 4 == 0) ? -16'sd32768 : 16'sd32767;
        else if (f < 840) return 16'($urandom);
        else if (f < 1020) begin sym = -1; amp = 12000; end
        else begin sym = 1; amp = 25000; end
        return 16'((f % 4 == 0) ? sym * amp : -sym * amp);
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NFRAMES * FLEN; c++) begin
            drv = stim(c);
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, NFRAMES * FLEN);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule